// File: doc/BRIEF.md
# Translation Unit Control Register Block with Cache Invalidation Sequencer

This block is the software-visible control face of a small DMA address-translation unit. A 32-bit register port with a valid/ready request and a registered read response gives software access to per-stream translation enables, four table base slots per stream (each with its own valid flag), a stream selection mask, and a cache operation register. The stored values drive the translation datapath directly through flat output buses.

Writing the flush command to the cache operation register snapshots the stream selection mask and begins an invalidation sequence. The sequencer walks the selected streams from lowest to highest number. It presents a one-hot invalidate strobe for the current stream, holds it until the attached translation cache acknowledges, and then moves on. A busy flag, readable in the operation register, stays set until every selected stream has been acknowledged. Software writes the mask, issues the flush, and polls busy until it reads clear.

Top module: `iommu_ctl_regs`

## Requirements
- R1: After reset every register reads zero, except the stream selection mask at offset 0x34, which reads 0xFFFF; no invalidate strobe is driven and all translation enables are low.
- R2: The word at 0x100 + 4*n (n below the stream count) keeps only bit 7 as the translation enable of stream n, drives it on `xlate_en_o[n]`, and reads back with all other bits zero.
- R3: The word at 0x200 + 16*n + 4*k (slot k = 0..3) stores a page frame number in bits PFN_W-1:0 and a valid flag in bit 31; the other bits read zero, and entry n*4+k appears on `tbl_valid_o` and on `tbl_pfn_o` at bits (n*4+k)*PFN_W upward.
- R4: The stream selection mask at 0x34 stores bits 15:0 of a write and reads back with the upper bits zero.
- R5: A write to 0x20 with bit 20 set, while idle, sets busy at the next clock edge; a read of 0x20 returns busy in bit 2 and zeros elsewhere.
- R6: During a flush `inv_strobe_o` is one-hot, selects only streams whose bit was set in the mask when the flush was issued, visits them in ascending order, holds each until `inv_ack_i` is sampled high, and advances one stream per acknowledged cycle.
- R7: Busy clears at the clock edge that accepts the acknowledge for the last selected stream; a flush with an empty mask ends without any strobe and reads idle two cycles after the command.
- R8: A flush command written while busy is ignored, and mask writes during a flush do not change the streams it visits.
- R9: Reads of unmapped or misaligned offsets return zero and writes to them change no register.
- R10: `req_ready` is always high and a read accepted at a clock edge produces `rsp_valid` with its data after that edge, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request accepted (always high) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| xlate_en_o | output | NUM_STREAMS | Per-stream translation enable |
| tbl_valid_o | output | NUM_STREAMS*4 | Per-slot valid flag, entry n*4+k |
| tbl_pfn_o | output | NUM_STREAMS*4*PFN_W | Per-slot page frame number, entry n*4+k |
| inv_strobe_o | output | NUM_STREAMS | One-hot invalidate request to the translation cache |
| inv_ack_i | input | 1 | Cache acknowledges the current invalidate |

## Verification
Read data is registered, so each read result is due one edge after the request is accepted; the bench drives requests on the falling edge, removes them at the next falling edge, and samples the response there. Busy and the first strobe appear one edge after the flush write, so they are observed at the falling edge right after the write, and each later strobe is checked at the falling edge following the edge that sampled the previous acknowledge. Holding the acknowledge low for chosen cycles lets the bench confirm that a strobe stays put and that the number of cycles of a flush equals the selected streams plus the stall cycles.

// File: rtl/iommu_ctl_pkg.sv
package iommu_ctl_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int MAX_STREAMS = 16;
    localparam int SID_W       = $clog2(MAX_STREAMS);
    localparam int SLOTS       = 4;
    localparam int SLOT_W      = $clog2(SLOTS);

    localparam logic [ADDR_W-1:0] OFS_CACHE_OP = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_SEL_MASK = 12'h034;
    localparam logic [5:0]        CFG_PAGE     = 6'h04;   // 0x100..0x13F
    localparam logic [3:0]        TBL_PAGE     = 4'h2;    // 0x200..0x2FF

    localparam int FLUSH_BIT = 20;
    localparam int BUSY_BIT  = 2;
    localparam int EN_BIT    = 7;
    localparam int VALID_BIT = 31;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CACHE_OP,
        RK_SEL_MASK,
        RK_STREAM_CFG,
        RK_TABLE_BASE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [SID_W-1:0]  sid;
        logic [SLOT_W-1:0] slot;
    } reg_sel_t;

    function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_t r;
        r.kind = RK_NONE;
        r.sid  = '0;
        r.slot = '0;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_CACHE_OP) begin
                r.kind = RK_CACHE_OP;
            end else if (a == OFS_SEL_MASK) begin
                r.kind = RK_SEL_MASK;
            end else if (a[11:6] == CFG_PAGE) begin
                r.kind = RK_STREAM_CFG;
                r.sid  = a[5:2];
            end else if (a[11:8] == TBL_PAGE) begin
                r.kind = RK_TABLE_BASE;
                r.sid  = a[7:4];
                r.slot = a[3:2];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/iommu_ctl_stream_regs.sv
module iommu_ctl_stream_regs
    import iommu_ctl_pkg::*;
#(
    parameter int NUM_STREAMS = 16,
    parameter int PFN_W       = 24
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  reg_sel_t                        sel,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_STREAMS-1:0]          xlate_en,
    output logic [NUM_STREAMS*SLOTS-1:0]    tbl_valid,
    output logic [NUM_STREAMS*SLOTS*PFN_W-1:0] tbl_pfn,
    output logic [DATA_W-1:0]               rdata
);
    localparam int ENTRIES = NUM_STREAMS * SLOTS;
    localparam int PAD_W   = DATA_W - 1 - PFN_W;

    logic in_range;
    assign in_range = (int'(sel.sid) < NUM_STREAMS);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        always_ff @(posedge clk) begin
            if (rst) begin
                xlate_en[s] <= 1'b0;
            end else if (wr_en && sel.kind == RK_STREAM_CFG && sel.sid == SID_W'(s)) begin
                xlate_en[s] <= wdata[EN_BIT];
            end
        end

        for (genvar k = 0; k < SLOTS; k++) begin : g_slot
            localparam int E = s * SLOTS + k;
            always_ff @(posedge clk) begin
                if (rst) begin
                    tbl_valid[E]               <= 1'b0;
                    tbl_pfn[E*PFN_W +: PFN_W]  <= '0;
                end else if (wr_en && sel.kind == RK_TABLE_BASE &&
                             sel.sid == SID_W'(s) && sel.slot == SLOT_W'(k)) begin
                    tbl_valid[E]               <= wdata[VALID_BIT];
                    tbl_pfn[E*PFN_W +: PFN_W]  <= wdata[PFN_W-1:0];
                end
            end
        end
    end

    always_comb begin
        int idx;
        idx   = int'(sel.sid) * SLOTS + int'(sel.slot);
        rdata = '0;
        if (in_range) begin
            if (sel.kind == RK_STREAM_CFG) begin
                rdata[EN_BIT] = xlate_en[sel.sid];
            end else if (sel.kind == RK_TABLE_BASE && idx < ENTRIES) begin
                rdata = {tbl_valid[idx], {PAD_W{1'b0}}, tbl_pfn[idx*PFN_W +: PFN_W]};
            end
        end
    end

endmodule

// File: rtl/iommu_ctl_flush_seq.sv
module iommu_ctl_flush_seq #(
    parameter int NUM_STREAMS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [NUM_STREAMS-1:0] sel_mask,
    input  logic                   inv_ack,
    output logic                   busy,
    output logic [NUM_STREAMS-1:0] inv_strobe
);
    logic [NUM_STREAMS-1:0] pending_q;
    logic [NUM_STREAMS-1:0] lowest;
    logic [NUM_STREAMS-1:0] pending_nx;
    logic                   busy_q;

    // Isolate the lowest pending stream: ascending service order.
    assign lowest     = pending_q & (~pending_q + NUM_STREAMS'(1));
    assign inv_strobe = busy_q ? lowest : '0;
    assign pending_nx = inv_ack ? (pending_q & ~lowest) : pending_q;
    assign busy       = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            pending_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q    <= 1'b1;
                pending_q <= sel_mask;
            end
        end else begin
            pending_q <= pending_nx;
            if (pending_nx == '0) begin
                busy_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iommu_ctl_regs.sv
module iommu_ctl_regs
    import iommu_ctl_pkg::*;
#(
    parameter int NUM_STREAMS = 16,
    parameter int PFN_W       = 24
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   req_valid,
    input  logic                                   req_write,
    input  logic [11:0]                            req_addr,
    input  logic [31:0]                            req_wdata,
    output logic                                   req_ready,
    output logic                                   rsp_valid,
    output logic [31:0]                            rsp_rdata,
    output logic [NUM_STREAMS-1:0]                 xlate_en_o,
    output logic [NUM_STREAMS*4-1:0]               tbl_valid_o,
    output logic [NUM_STREAMS*4*PFN_W-1:0]         tbl_pfn_o,
    output logic [NUM_STREAMS-1:0]                 inv_strobe_o,
    input  logic                                   inv_ack_i
);
    reg_sel_t               sel;
    logic                   wr_en;
    logic                   rd_en;
    logic [NUM_STREAMS-1:0] mask_q;
    logic                   flush_busy;
    logic                   flush_start;
    logic [DATA_W-1:0]      stream_rd;
    logic [DATA_W-1:0]      rd_mux;

    assign req_ready   = 1'b1;
    assign sel         = decode_offset(req_addr);
    assign wr_en       = req_valid && req_write;
    assign rd_en       = req_valid && !req_write;
    assign flush_start = wr_en && sel.kind == RK_CACHE_OP && req_wdata[FLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (wr_en && sel.kind == RK_SEL_MASK) begin
            mask_q <= req_wdata[NUM_STREAMS-1:0];
        end
    end

    iommu_ctl_stream_regs #(
        .NUM_STREAMS(NUM_STREAMS),
        .PFN_W      (PFN_W)
    ) u_streams (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (req_wdata),
        .xlate_en (xlate_en_o),
        .tbl_valid(tbl_valid_o),
        .tbl_pfn  (tbl_pfn_o),
        .rdata    (stream_rd)
    );

    iommu_ctl_flush_seq #(
        .NUM_STREAMS(NUM_STREAMS)
    ) u_flush (
        .clk       (clk),
        .rst       (rst),
        .start     (flush_start),
        .sel_mask  (mask_q),
        .inv_ack   (inv_ack_i),
        .busy      (flush_busy),
        .inv_strobe(inv_strobe_o)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sel.kind)
            RK_CACHE_OP:   rd_mux[BUSY_BIT] = flush_busy;
            RK_SEL_MASK:   rd_mux[NUM_STREAMS-1:0] = mask_q;
            RK_STREAM_CFG,
            RK_TABLE_BASE: rd_mux = stream_rd;
            default:       rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/iommu_ctl_regs_chk.sv
module iommu_ctl_regs_chk #(
    parameter int NUM_STREAMS = 16
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [11:0]            req_addr,
    input logic [31:0]            req_wdata,
    input logic                   rsp_valid,
    input logic [NUM_STREAMS-1:0] inv_strobe,
    input logic                   inv_ack,
    input logic                   busy
);
    // R6: never more than one stream invalidated at a time
    p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(inv_strobe));

    // R6: a strobe only appears inside a flush
    p_strobe_in_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (inv_strobe != '0) |-> busy);

    // R6: an unacknowledged strobe is held
    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (inv_strobe != '0 && !inv_ack) |=> $stable(inv_strobe));

    // R6: after an acknowledge the next stream is strictly higher, or the flush ends
    p_ascending_r6: assert property (@(posedge clk) disable iff (rst)
        (inv_strobe != '0 && inv_ack) |=> (inv_strobe == '0 || inv_strobe > $past(inv_strobe)));

    // R5: busy rises only after a flush command write
    p_busy_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid && req_write && req_addr == 12'h020 && req_wdata[20]));

    // R10: every accepted read yields a response in the next cycle
    p_read_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R10: no response without a read
    p_no_spurious_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

endmodule

bind iommu_ctl_regs iommu_ctl_regs_chk #(.NUM_STREAMS(NUM_STREAMS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .inv_strobe(inv_strobe_o),
    .inv_ack   (inv_ack_i),
    .busy      (flush_busy)
);

// File: tb/sim_iommu_ctl_regs.sv
`timescale 1ns/1ps
module sim_iommu_ctl_regs;
    localparam int NS    = 16;
    localparam int PFN_W = 24;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic                      req_valid = 1'b0;
    logic                      req_write = 1'b0;
    logic [11:0]               req_addr  = '0;
    logic [31:0]               req_wdata = '0;
    logic                      req_ready;
    logic                      rsp_valid;
    logic [31:0]               rsp_rdata;
    logic [NS-1:0]             xlate_en_o;
    logic [NS*4-1:0]           tbl_valid_o;
    logic [NS*4*PFN_W-1:0]     tbl_pfn_o;
    logic [NS-1:0]             inv_strobe_o;
    logic                      inv_ack_i = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    iommu_ctl_regs #(.NUM_STREAMS(NS), .PFN_W(PFN_W)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .xlate_en_o(xlate_en_o), .tbl_valid_o(tbl_valid_o), .tbl_pfn_o(tbl_pfn_o),
        .inv_strobe_o(inv_strobe_o), .inv_ack_i(inv_ack_i)
    );

    // {offset, write data, expected read-back}
    localparam logic [75:0] VEC [9] = '{
        {12'h10C, 32'hFFFF_FFFF, 32'h0000_0080},  // R2 stream 3 enable
        {12'h13C, 32'h0000_0080, 32'h0000_0080},  // R2 stream 15 enable
        {12'h100, 32'h0000_007F, 32'h0000_0000},  // R2 other bits dropped
        {12'h234, 32'hFFFF_FFFF, 32'h80FF_FFFF},  // R3 stream 3 slot 1
        {12'h2FC, 32'h00AB_CDEF, 32'h00AB_CDEF},  // R3 stream 15 slot 3
        {12'h034, 32'hFFFF_1234, 32'h0000_1234},  // R4 mask
        {12'h010, 32'hDEAD_BEEF, 32'h0000_0000},  // R9 unmapped
        {12'h140, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 past config window
        {12'h10E, 32'hFFFF_FFFF, 32'h0000_0000}   // R9 misaligned
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({31'b0, rsp_valid}, 32'd1, "R10 rsp_valid");
        d = rsp_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int exp_sid [4] = '{0, 2, 5, 11};
        int idx;
        int hold;
        int steps;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check({31'b0, req_ready}, 32'd1, "R10 ready");
        check({16'b0, xlate_en_o}, 32'd0, "R1 enables");
        check({16'b0, inv_strobe_o}, 32'd0, "R1 strobe");
        bus_read(12'h034, rd); check(rd, 32'h0000_FFFF, "R1 mask reset");
        bus_read(12'h020, rd); check(rd, 32'h0, "R1 op reset");
        bus_read(12'h13C, rd); check(rd, 32'h0, "R1 cfg reset");
        bus_read(12'h2FC, rd); check(rd, 32'h0, "R1 table reset");
        @(negedge clk);
        check({31'b0, rsp_valid}, 32'd0, "R10 single-cycle rsp");

        // Vector table: R2 R3 R4 R9
        for (int i = 0; i < 9; i++) begin
            bus_write(VEC[i][75:64], VEC[i][63:32]);
            bus_read(VEC[i][75:64], rd);
            check(rd, VEC[i][31:0], $sformatf("vector %0d (R2,R3,R4,R9)", i));
        end
        bus_read(12'h100, rd); check(rd, 32'h0, "R9 misaligned write ignored");
        check({16'b0, xlate_en_o}, 32'h0000_8008, "R2 enable outputs");
        check({31'b0, tbl_valid_o[13]}, 32'd1, "R3 valid s3k1");
        check({8'b0, tbl_pfn_o[13*PFN_W +: PFN_W]}, 32'h00FF_FFFF, "R3 pfn s3k1");
        check({31'b0, tbl_valid_o[63]}, 32'd0, "R3 valid s15k3");
        check({8'b0, tbl_pfn_o[63*PFN_W +: PFN_W]}, 32'h00AB_CDEF, "R3 pfn s15k3");

        // R5 / R8: flush held by a missing acknowledge
        bus_write(12'h034, 32'h0000_0001);
        bus_write(12'h020, 32'h0010_0000);
        check({16'b0, inv_strobe_o}, 32'h0001, "R5 first strobe next cycle");
        bus_read(12'h020, rd); check(rd, 32'h0000_0004, "R5 busy reads set");
        bus_write(12'h034, 32'h0000_0002);
        bus_write(12'h020, 32'h0010_0000);
        check({16'b0, inv_strobe_o}, 32'h0001, "R8 mask change ignored");
        inv_ack_i = 1'b1;
        @(negedge clk);
        inv_ack_i = 1'b0;
        check({16'b0, inv_strobe_o}, 32'h0, "R7 strobe gone after ack");
        bus_read(12'h020, rd); check(rd, 32'h0, "R7 busy clear");
        check({16'b0, inv_strobe_o}, 32'h0, "R8 second flush ignored");

        // R6 / R7: four streams, stream 2 stalled two cycles
        bus_write(12'h034, 32'h0000_0825);
        bus_write(12'h020, 32'h0010_0000);
        idx = 0; hold = 0; steps = 0;
        while (idx < 4 && steps < 20) begin
            check({16'b0, inv_strobe_o}, 32'(1) << exp_sid[idx], "R6 strobe order");
            if (exp_sid[idx] == 2 && hold < 2) begin
                inv_ack_i = 1'b0; hold++;
            end else begin
                inv_ack_i = 1'b1; idx++;
            end
            steps++;
            @(negedge clk);
        end
        inv_ack_i = 1'b0;
        check(32'(steps), 32'd6, "R6 one stream per acked cycle");
        check({16'b0, inv_strobe_o}, 32'h0, "R7 no strobe after last ack");
        bus_read(12'h020, rd); check(rd, 32'h0, "R7 busy clear after sequence");

        // R7: empty mask
        bus_write(12'h034, 32'h0000_0000);
        bus_write(12'h020, 32'h0010_0000);
        check({16'b0, inv_strobe_o}, 32'h0, "R7 empty mask no strobe");
        bus_read(12'h020, rd); check(rd, 32'h0, "R7 empty mask idle");

        // R5: op write without bit 20 does not start a flush
        bus_write(12'h034, 32'h0000_0001);
        bus_write(12'h020, 32'hFFEF_FFFF);
        check({16'b0, inv_strobe_o}, 32'h0, "R5 no flush without command bit");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule